// File: doc/BRIEF.md
# Vector Table-Lookup Permute Unit

This unit assembles a destination vector lane by lane. Each lane of an index vector selects one element from a lookup table. The table is either a single vector, or two vectors laid end to end so that the second continues the numbering of the first. The element width can be 8, 16, 32 or 64 bits within a fixed vector width. The lane count is therefore the vector width divided by the element width.

A lane whose index lies beyond every enabled table is handled by one of two policies. Zeroing clears the lane. Merging copies the lane from the previous destination vector, which is supplied on its own input. All operands are captured at the clock edge where `start` is high. The finished vector appears one cycle later, together with `result_valid`. Because of this capture, a destination that is also a table source never sees a partly updated table.

Top module: `vtbl_permute`

## Requirements
- R1: The element width is set by `esize`: code 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. The lane count N equals VEC_BITS divided by the element width. Lane i, and element i of every vector, occupies bits [i*EW +: EW], with lane 0 at the least significant end.
- R2: Each lane's index is the unsigned value of that lane of `idx_vec`. An index below N selects element `index` of `tbl_a`.
- R3: In zeroing mode with `two_tbl`=1, an index in the range N to 2N-1 selects element `index-N` of `tbl_b`.
- R4: In zeroing mode (`merge_en`=0), a lane whose index is at least N (single table) or at least 2N (two tables) becomes zero.
- R5: In merge mode (`merge_en`=1), a lane whose index is at least N takes the same lane of `old_dst`.
- R6: In merge mode, `two_tbl` has no effect, so `tbl_b` is never consulted and indices from N to 2N-1 count as out of range.
- R7: `result_valid` is high in exactly the cycle after a cycle with `start` high, and low otherwise. `result` changes only in that cycle and holds its value while no operation completes.
- R8: The result depends only on the operands present at the `start` edge. Changing the inputs afterwards, or presenting the same vector on `tbl_a` and `old_dst`, does not alter it.
- R9: While `rst_n` is low, `result` is all zeros and `result_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture the operands and launch one lookup |
| esize | input | 2 | Element width code (0:8, 1:16, 2:32, 3:64 bits) |
| merge_en | input | 1 | 1 = out-of-range lanes keep `old_dst`, 0 = they are zeroed |
| two_tbl | input | 1 | 1 = `tbl_b` extends the table (zeroing mode only) |
| tbl_a | input | VEC_BITS | First table vector |
| tbl_b | input | VEC_BITS | Second table vector |
| idx_vec | input | VEC_BITS | Per-lane index vector |
| old_dst | input | VEC_BITS | Previous destination contents |
| result_valid | output | 1 | Result is present this cycle |
| result | output | VEC_BITS | Permuted vector |

## Verification
The bench goes after the range boundaries at every element width: indices of exactly N, 2N-1, 2N and all ones, plus identity and reversal patterns, under all four combinations of mode and table count. A design that tests the range with an off-by-one compare would take a neighbour element or a stale lane at N or 2N. A design that lets `two_tbl` act in merge mode would pull `tbl_b` data where `old_dst` belongs. Operands are scrambled right after each `start`, and one case aliases `old_dst` with `tbl_a`, so an unregistered or partly updated path would show up as a mismatch.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;

   typedef enum logic [1:0] {
      ESZ_8  = 2'd0,
      ESZ_16 = 2'd1,
      ESZ_32 = 2'd2,
      ESZ_64 = 2'd3
   } elem_size_e;

   localparam int unsigned NUM_SIZES = 4;

endpackage

// File: rtl/vtbl_lane.sv
// One destination lane: decode the index, fetch from table A or table B,
// or fall back to zero / previous destination.
module vtbl_lane #(
   parameter int unsigned VEC_BITS = 128,
   parameter int unsigned EW       = 8
) (
   input  logic [VEC_BITS-1:0] tbl_a,
   input  logic [VEC_BITS-1:0] tbl_b,
   input  logic [EW-1:0]       lane_idx,
   input  logic [EW-1:0]       lane_old,
   input  logic                merge_en,
   input  logic                two_tbl,
   output logic [EW-1:0]       lane_out
);
   localparam int unsigned NELEM = VEC_BITS / EW;
   localparam int unsigned LW    = $clog2(NELEM);
   localparam int unsigned ELW   = $clog2(EW);
   localparam int unsigned AW    = LW + ELW;

   logic [EW-1:0] upper;
   logic [LW-1:0] pos;
   logic [AW-1:0] bit_ofs;
   logic          hit_a;
   logic          hit_b;

   always_comb begin
      upper   = lane_idx >> LW;
      pos     = lane_idx[LW-1:0];
      bit_ofs = {pos, {ELW{1'b0}}};
      hit_a   = (upper == '0);
      hit_b   = (upper == EW'(1)) && two_tbl && !merge_en;
      if (hit_a)
         lane_out = tbl_a[bit_ofs +: EW];
      else if (hit_b)
         lane_out = tbl_b[bit_ofs +: EW];
      else if (merge_en)
         lane_out = lane_old;
      else
         lane_out = '0;
   end

endmodule

// File: rtl/vtbl_size_path.sv
// Full permute for one fixed element width: one lane instance per element.
module vtbl_size_path #(
   parameter int unsigned VEC_BITS = 128,
   parameter int unsigned EW       = 8
) (
   input  logic [VEC_BITS-1:0] tbl_a,
   input  logic [VEC_BITS-1:0] tbl_b,
   input  logic [VEC_BITS-1:0] idx_vec,
   input  logic [VEC_BITS-1:0] old_dst,
   input  logic                merge_en,
   input  logic                two_tbl,
   output logic [VEC_BITS-1:0] perm_out
);
   localparam int unsigned NELEM = VEC_BITS / EW;

   for (genvar ln = 0; ln < NELEM; ln++) begin : g_lane
      vtbl_lane #(
         .VEC_BITS (VEC_BITS),
         .EW       (EW)
      ) u_lane (
         .tbl_a    (tbl_a),
         .tbl_b    (tbl_b),
         .lane_idx (idx_vec[ln*EW +: EW]),
         .lane_old (old_dst[ln*EW +: EW]),
         .merge_en (merge_en),
         .two_tbl  (two_tbl),
         .lane_out (perm_out[ln*EW +: EW])
      );
   end

endmodule

// File: rtl/vtbl_permute.sv
// Top: parallel permute paths for each element width, width select, and
// a capture register that gives a one-cycle result.
module vtbl_permute
   import vtbl_pkg::*;
#(
   parameter int unsigned VEC_BITS = 128
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [1:0]          esize,
   input  logic                merge_en,
   input  logic                two_tbl,
   input  logic [VEC_BITS-1:0] tbl_a,
   input  logic [VEC_BITS-1:0] tbl_b,
   input  logic [VEC_BITS-1:0] idx_vec,
   input  logic [VEC_BITS-1:0] old_dst,
   output logic                result_valid,
   output logic [VEC_BITS-1:0] result
);
   localparam int unsigned MIN_BITS = 128;
   localparam int unsigned MAX_BITS = 1024;

   if (VEC_BITS < MIN_BITS || VEC_BITS > MAX_BITS ||
       (VEC_BITS & (VEC_BITS - 1)) != 0) begin : g_bad_width
      $error("vtbl_permute: VEC_BITS must be a power of two from 128 to 1024");
   end

   logic [VEC_BITS-1:0] size_res [NUM_SIZES];
   logic [VEC_BITS-1:0] sel_res;
   elem_size_e          esz;

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      vtbl_size_path #(
         .VEC_BITS (VEC_BITS),
         .EW       (8 << s)
      ) u_path (
         .tbl_a    (tbl_a),
         .tbl_b    (tbl_b),
         .idx_vec  (idx_vec),
         .old_dst  (old_dst),
         .merge_en (merge_en),
         .two_tbl  (two_tbl),
         .perm_out (size_res[s])
      );
   end

   always_comb begin
      esz = elem_size_e'(esize);
      case (esz)
         ESZ_8:   sel_res = size_res[0];
         ESZ_16:  sel_res = size_res[1];
         ESZ_32:  sel_res = size_res[2];
         default: sel_res = size_res[3];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_valid <= 1'b0;
         result       <= '0;
      end else begin
         result_valid <= start;
         if (start)
            result <= sel_res;
      end
   end

   AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> result_valid); // R7

   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !result_valid); // R7

   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(result)); // R7

   AST_MERGE_ALLONES_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && merge_en && (&idx_vec)) |=> (result == $past(old_dst))); // R5

   AST_ZERO_ALLONES_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !merge_en && !two_tbl && (&idx_vec)) |=> (result == '0)); // R4

endmodule

// File: tb/vtbl_permute_bench.sv
`timescale 1ns/1ps
module vtbl_permute_bench;
   localparam int VB = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    esize = '0;
   logic          merge_en = 1'b0;
   logic          two_tbl = 1'b0;
   logic [VB-1:0] tbl_a = '0;
   logic [VB-1:0] tbl_b = '0;
   logic [VB-1:0] idx_vec = '0;
   logic [VB-1:0] old_dst = '0;
   logic          result_valid;
   logic [VB-1:0] result;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   logic [VB-1:0] exp_q [$];
   string         tag_q [$];
   logic [VB-1:0] last_exp = '0;

   always #2 clk = ~clk;

   vtbl_permute #(.VEC_BITS(VB)) u_vtbl_permute (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .esize        (esize),
      .merge_en     (merge_en),
      .two_tbl      (two_tbl),
      .tbl_a        (tbl_a),
      .tbl_b        (tbl_b),
      .idx_vec      (idx_vec),
      .old_dst      (old_dst),
      .result_valid (result_valid),
      .result       (result)
   );

   function automatic logic [VB-1:0] rand_vec();
      logic [VB-1:0] v;
      for (int k = 0; k < VB / 32; k++) v[k*32 +: 32] = $urandom;
      return v;
   endfunction

   function automatic logic [63:0] get_el(logic [VB-1:0] v, int pos, int ew);
      logic [63:0] e = '0;
      for (int k = 0; k < ew; k++) e[k] = v[pos*ew + k];
      return e;
   endfunction

   function automatic logic [VB-1:0] ref_model(logic [VB-1:0] a, logic [VB-1:0] b,
         logic [VB-1:0] ix, logic [VB-1:0] od, int es, bit mrg, bit two);
      logic [VB-1:0] r = '0;
      int ew = 8 << es;
      int n  = VB / ew;
      for (int i = 0; i < n; i++) begin
         logic [63:0] id, val;
         id = get_el(ix, i, ew);
         if (id < 64'(n))                              val = get_el(a, int'(id), ew);
         else if (two && !mrg && id < 64'(2 * n))      val = get_el(b, int'(id) - n, ew);
         else if (mrg)                                 val = get_el(od, i, ew);
         else                                          val = '0;
         for (int k = 0; k < ew; k++) r[i*ew + k] = val[k];
      end
      return r;
   endfunction

   function automatic logic [VB-1:0] make_idx(int es, int kind);
      logic [VB-1:0] v = '0;
      int ew = 8 << es;
      int n  = VB / ew;
      for (int i = 0; i < n; i++) begin
         logic [63:0] id;
         case (kind)
            0: id = 64'($urandom_range(3 * n - 1, 0));
            1: id = 64'(n);
            2: id = 64'(2 * n);
            3: id = '1;
            4: id = 64'(2 * n - 1);
            5: id = 64'(i);
            6: id = 64'(n - 1 - i);
            default: id = 64'($urandom);
         endcase
         for (int k = 0; k < ew; k++) v[i*ew + k] = id[k];
      end
      return v;
   endfunction

   task automatic check(bit ok, string req, logic [VB-1:0] act, logic [VB-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // driver: apply one operation and push its expected result
   task automatic send(logic [VB-1:0] a, logic [VB-1:0] b, logic [VB-1:0] ix,
                       logic [VB-1:0] od, int es, bit mrg, bit two, string tag);
      @(negedge clk);
      tbl_a = a; tbl_b = b; idx_vec = ix; old_dst = od;
      esize = 2'(es); merge_en = mrg; two_tbl = two;
      start = 1'b1;
      last_exp = ref_model(a, b, ix, od, es, mrg, two);
      exp_q.push_back(last_exp);
      tag_q.push_back(tag);
   endtask

   // idle cycle with scrambled operands (R8)
   task automatic idle();
      @(negedge clk);
      start = 1'b0;
      tbl_a = rand_vec(); tbl_b = rand_vec(); idx_vec = rand_vec(); old_dst = rand_vec();
      merge_en = ~merge_en; two_tbl = ~two_tbl;
   endtask

   // monitor: pop and compare as results come out
   always @(negedge clk) begin
      if (rst_n && !finished && result_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected valid", result, '0);
         end else begin
            logic [VB-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(result === e, t, result, e);
         end
      end
   end

   task automatic report();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      report();
   end

   initial begin
      logic [VB-1:0] a, b, od;
      repeat (3) @(negedge clk);
      check(result === '0 && result_valid === 1'b0, "R9 reset state",
            result, '0);
      rst_n = 1'b1;
      for (int es = 0; es < 4; es++) begin
         for (int m = 0; m < 4; m++) begin
            for (int kind = 0; kind < 8; kind++) begin
               bit mrg = m[1];
               bit two = m[0];
               string tag;
               if (kind == 5 || kind == 6) tag = "R1 R2 lane order";
               else if (mrg && two)       tag = "R6 merge ignores second table";
               else if (mrg)              tag = "R5 merge keeps old lane";
               else if (two)              tag = "R3 two-table lookup";
               else                       tag = "R4 zeroing single table";
               if (kind == 0) tag = {tag, " R2 random"};
               send(rand_vec(), rand_vec(), make_idx(es, kind), rand_vec(), es, mrg, two, tag);
               if (kind[0]) idle();
            end
         end
      end
      // aliasing: previous destination equals table A
      for (int es = 0; es < 4; es++) begin
         a = rand_vec();
         send(a, rand_vec(), make_idx(es, 0), a, es, 1'b1, 1'b0, "R8 alias dst and table");
         idle();
      end
      // extra random mix, back to back
      for (int j = 0; j < 40; j++) begin
         send(rand_vec(), rand_vec(), make_idx(j % 4, 0), rand_vec(), j % 4,
              1'(j / 4 % 2), 1'(j / 8 % 2), "R2 R3 R4 R5 random mix");
      end
      idle();
      repeat (4) idle();
      check(result_valid === 1'b0 && result === last_exp, "R7 R8 hold after idle",
            result, last_exp);
      check(exp_q.size() == 0, "R7 all results delivered",
            VB'(exp_q.size()), '0);
      report();
   end

endmodule